// File: doc/BRIEF.md
# Zero-Cross Gated Volume Update Controller

This block is the digital control for two input gain stages, A and B, that share one update control. Software writes a volume code, a mute bit and a zero-cross enable for each stage through a small register write port. A volume code that has been written sits in a pending register. It reaches the active gain output only when a write sets the update bit, and that write commits stage A and stage B together.

For a stage with zero-cross gating enabled, the commit waits until that stage's signed sample stream crosses zero. This avoids audible steps in the gain. If no crossing arrives, a shared timeout counter forces the commit. The timeout counts ticks only while its enable is set, and a 2-bit rate field sets its length.

A mode bit selects single-ended or differential operation. In differential mode stage B is unused and is reported as muted with zero gain. The reported gain in decibels depends on the mode.

Top module: `zc_vol_ctrl`

Register map (write-only; `wr_data_i` is 9 bits):

- Address 0, control: bit 0 is the mode (1 = differential), bit 1 is the timeout enable, and bits 3:2 are the timeout rate.
- Address 1 is stage A and address 2 is stage B. In both, bits 5:0 hold the volume code, bit 6 is mute, bit 7 is zero-cross enable and bit 8 is update.
- Address 3 is not decoded.

## Requirements
- R1: After reset both active codes equal 6, both mutes are 1, the mode is differential, and `gain_db_a_o` reads 0.
- R2: A write to address 1 or 2 with bit 8 at 0 changes the pending code only. The active gain outputs stay unchanged until a later commit.
- R3: A write with bit 8 set commits the pending codes of both stages. The codes include the value written in that same write. A stage with zero-cross disabled shows its new code on the clock edge of that write.
- R4: A stage with zero-cross enabled holds its old active code after the update write. It commits on the first later edge at which its own sample shows a crossing. Each stage waits independently of the other.
- R5: A crossing is seen when the sample equals zero, or when its sign bit differs from the sign bit of the sample taken on the previous edge.
- R6: If no crossing occurs, a pending commit is forced on the 2^(8+2*rate)-th timeout tick after the update write. Ticks count only while the timeout enable (address 0 bit 1) is 1.
- R7: A new update write replaces any commit still pending. The code finally applied is the pending code at the newest update write.
- R8: Mute bit 6 of a stage register takes effect on the edge of the write, independent of the update bit.
- R9: In differential mode `mute_b_o` is 1 and both `gain_b_o` and `gain_db_b_o` are 0.
- R10: Reported gain in dB equals min(code,24) in single-ended mode and min(code,24)-6 in differential mode.
- R11: Writes to address 3 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 9 | Register write data |
| smp_a_i | input | 16 | Signed sample of stage A |
| smp_b_i | input | 16 | Signed sample of stage B |
| tick_i | input | 1 | Timeout tick |
| gain_a_o | output | 6 | Active code, stage A |
| gain_b_o | output | 6 | Active code, stage B (0 in differential mode) |
| gain_db_a_o | output | 7 | Signed gain in dB, stage A |
| gain_db_b_o | output | 7 | Signed gain in dB, stage B |
| mute_a_o | output | 1 | Mute, stage A |
| mute_b_o | output | 1 | Mute, stage B |

## Verification
A wrong pending or target register only shows at the ports on the next commit. For that reason every update write is followed by a check on the edge where the commit must land. A stuck pending flag or a misplaced crossing detector shows as a gain change one edge early or late around a sign change. A wrong timeout load or wrong tick gating shows as a commit one tick before or after 2^(8+2*rate). The timeout is therefore checked on both sides of that edge.

// File: rtl/zc_vol_pkg.sv
package zc_vol_pkg;
  localparam int CODE_W   = 6;
  localparam int DB_W     = 7;
  localparam int WR_W     = 9;
  localparam int RATE_W   = 2;
  localparam int NSTG     = 2;
  localparam int CODE_RST = 6;
  localparam int CODE_MAX = 24;
  localparam int DIFF_OFS = 6;
  localparam int MUTE_BIT = 6;
  localparam int ZC_BIT   = 7;
  localparam int UPD_BIT  = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STG0 = 2'd1;

  function automatic logic signed [DB_W-1:0] code_to_db(input logic [CODE_W-1:0] c, input logic diff);
    logic [CODE_W-1:0] sat;
    sat = (c > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : c;
    return diff ? DB_W'(signed'({1'b0, sat}) - DB_W'(DIFF_OFS)) : DB_W'({1'b0, sat});
  endfunction
endpackage

// File: rtl/zc_vol_regs.sv
module zc_vol_regs import zc_vol_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [WR_W-1:0]   wr_data_i,
  output logic              diff_o,
  output logic              to_ena_o,
  output logic [RATE_W-1:0] to_rate_o,
  output logic [NSTG-1:0]   mute_o,
  output logic [NSTG-1:0]   zc_en_o,
  output logic [NSTG-1:0]   vol_we_o,
  output logic              upd_o
);
  logic ctrl_we;
  logic [NSTG-1:0] zc_q;

  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_o    <= 1'b1;
      to_ena_o  <= 1'b0;
      to_rate_o <= '0;
    end else if (ctrl_we) begin
      diff_o    <= wr_data_i[0];
      to_ena_o  <= wr_data_i[1];
      to_rate_o <= wr_data_i[2 +: RATE_W];
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    assign vol_we_o[s] = wr_en_i && (wr_addr_i == ADDR_STG0 + 2'(s));
    // next-state zero-cross enable, so a write with update uses its own bit
    assign zc_en_o[s]  = vol_we_o[s] ? wr_data_i[ZC_BIT] : zc_q[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mute_o[s] <= 1'b1;
        zc_q[s]   <= 1'b0;
      end else if (vol_we_o[s]) begin
        mute_o[s] <= wr_data_i[MUTE_BIT];
        zc_q[s]   <= wr_data_i[ZC_BIT];
      end
    end
  end

  assign upd_o = (|vol_we_o) && wr_data_i[UPD_BIT];
endmodule

// File: rtl/zc_detect.sv
module zc_detect #(
  parameter int SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  output logic             zc_o
);
  logic prev_neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_neg_q <= 1'b0;
    else         prev_neg_q <= smp_i[SMP_W-1];
  end

  assign zc_o = (smp_i == '0) || (smp_i[SMP_W-1] != prev_neg_q);
endmodule

// File: rtl/zc_timer.sv
module zc_timer #(
  parameter int RATE_W   = 2,
  parameter int BASE_LG2 = 8,
  parameter int STEP_LG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ena_i,
  input  logic              tick_i,
  output logic              fire_o
);
  localparam int MAX_LG2 = BASE_LG2 + STEP_LG2 * ((1 << RATE_W) - 1);
  localparam int CNT_W   = MAX_LG2 + 1;

  logic [CNT_W-1:0] cnt_q, load_val;
  logic             step;

  assign load_val = CNT_W'(1) << (BASE_LG2 + STEP_LG2 * int'(rate_i));
  assign step     = ena_i && tick_i && (cnt_q != '0);
  assign fire_o   = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val;
    else if (step)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/zc_stage.sv
module zc_stage import zc_vol_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vol_we_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              upd_i,
  input  logic              zc_en_i,
  input  logic              zc_i,
  input  logic              fire_i,
  output logic [CODE_W-1:0] active_o,
  output logic              pend_o
);
  logic [CODE_W-1:0] shadow_q, shadow_d, target_q;

  assign shadow_d = vol_we_i ? wr_code_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CODE_W'(CODE_RST);
      target_q <= CODE_W'(CODE_RST);
      active_o <= CODE_W'(CODE_RST);
      pend_o   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      if (upd_i) begin
        if (zc_en_i) begin
          target_q <= shadow_d;
          pend_o   <= 1'b1;
        end else begin
          active_o <= shadow_d;
          pend_o   <= 1'b0;
        end
      end else if (pend_o && (zc_i || fire_i)) begin
        active_o <= target_q;
        pend_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zc_vol_ctrl.sv
module zc_vol_ctrl import zc_vol_pkg::*; #(
  parameter int SMP_W    = 16,
  parameter int TO_BASE  = 8,
  parameter int TO_STEP  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_addr_i,
  input  logic [WR_W-1:0]        wr_data_i,
  input  logic [SMP_W-1:0]       smp_a_i,
  input  logic [SMP_W-1:0]       smp_b_i,
  input  logic                   tick_i,
  output logic [CODE_W-1:0]      gain_a_o,
  output logic [CODE_W-1:0]      gain_b_o,
  output logic signed [DB_W-1:0] gain_db_a_o,
  output logic signed [DB_W-1:0] gain_db_b_o,
  output logic                   mute_a_o,
  output logic                   mute_b_o
);
  logic              diff_q, to_ena_q, upd_req, to_fire;
  logic [RATE_W-1:0] to_rate_q;
  logic [NSTG-1:0]   mute_q, zc_en, vol_we, zc_hit, pend;
  logic [SMP_W-1:0]  smp [NSTG];
  logic [CODE_W-1:0] act [NSTG];

  assign smp[0] = smp_a_i;
  assign smp[1] = smp_b_i;

  zc_vol_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .diff_o(diff_q), .to_ena_o(to_ena_q), .to_rate_o(to_rate_q),
    .mute_o(mute_q), .zc_en_o(zc_en), .vol_we_o(vol_we), .upd_o(upd_req)
  );

  zc_timer #(.RATE_W(RATE_W), .BASE_LG2(TO_BASE), .STEP_LG2(TO_STEP)) u_timer (
    .clk_i, .rst_ni, .load_i(upd_req), .rate_i(to_rate_q),
    .ena_i(to_ena_q), .tick_i, .fire_o(to_fire)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    zc_detect #(.SMP_W(SMP_W)) u_det (
      .clk_i, .rst_ni, .smp_i(smp[s]), .zc_o(zc_hit[s])
    );
    zc_stage u_stg (
      .clk_i, .rst_ni, .vol_we_i(vol_we[s]), .wr_code_i(wr_data_i[CODE_W-1:0]),
      .upd_i(upd_req), .zc_en_i(zc_en[s]), .zc_i(zc_hit[s]), .fire_i(to_fire),
      .active_o(act[s]), .pend_o(pend[s])
    );
  end

  // stage B is unused in differential mode
  assign gain_a_o    = act[0];
  assign gain_b_o    = diff_q ? '0 : act[1];
  assign gain_db_a_o = code_to_db(act[0], diff_q);
  assign gain_db_b_o = diff_q ? '0 : code_to_db(act[1], 1'b0);
  assign mute_a_o    = mute_q[0];
  assign mute_b_o    = mute_q[1] | diff_q;
endmodule

// File: rtl/zc_vol_ctrl_chk.sv
module zc_vol_ctrl_chk import zc_vol_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [WR_W-1:0]   wr_data_i,
  input logic [CODE_W-1:0] gain_a_o,
  input logic [CODE_W-1:0] gain_b_o,
  input logic              mute_a_o,
  input logic              mute_b_o,
  input logic              pend_a_i,
  input logic              zc_a_i,
  input logic              fire_i,
  input logic              to_ena_i
);
  // R2
  hold_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1 && !wr_data_i[UPD_BIT] && !pend_a_i) |=> $stable(gain_a_o));
  // R3
  commit_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1 && wr_data_i[UPD_BIT] && !wr_data_i[ZC_BIT])
      |=> gain_a_o == $past(wr_data_i[CODE_W-1:0]));
  // R4
  zc_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_a_i && !zc_a_i && !fire_i && !wr_en_i) |=> ($stable(gain_a_o) && pend_a_i));
  // R6
  fire_ena_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> to_ena_i);
  // R8
  mute_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1) |=> mute_a_o == $past(wr_data_i[MUTE_BIT]));
  // R9
  diff_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0 && wr_data_i[0]) |=> (mute_b_o && gain_b_o == '0));
endmodule

bind zc_vol_ctrl zc_vol_ctrl_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
  .gain_a_o, .gain_b_o, .mute_a_o, .mute_b_o,
  .pend_a_i(pend[0]), .zc_a_i(zc_hit[0]), .fire_i(to_fire), .to_ena_i(to_ena_q)
);

// File: tb/zc_vol_ctrl_tb.sv
module zc_vol_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [8:0] wr_data = 0;
  logic [15:0] smp_a = 16'd5, smp_b = 16'd5;
  logic tick = 0;
  logic [5:0] gain_a, gain_b;
  logic signed [6:0] db_a, db_b;
  logic mute_a, mute_b;
  int total = 0, bad = 0;

  // model state
  logic [5:0] m_sh_a = 6, m_sh_b = 6, m_act_a = 6, m_act_b = 6;
  logic m_mute_a = 1, m_mute_b = 1, m_diff = 1;

  always #2.5 clk = ~clk;

  zc_vol_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .smp_a_i(smp_a), .smp_b_i(smp_b), .tick_i(tick),
    .gain_a_o(gain_a), .gain_b_o(gain_b), .gain_db_a_o(db_a), .gain_db_b_o(db_b),
    .mute_a_o(mute_a), .mute_b_o(mute_b)
  );

  function automatic int exp_db(input logic [5:0] c, input logic d);
    int v;
    v = (c > 24) ? 24 : int'(c);
    return d ? v - 6 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_model(input string req);
    chk({req, " gain_a"}, int'(gain_a), int'(m_act_a));
    chk({req, " gain_b"}, int'(gain_b), m_diff ? 0 : int'(m_act_b));
    chk({req, " db_a"}, int'(db_a), exp_db(m_act_a, m_diff));
    chk({req, " db_b"}, int'(db_b), m_diff ? 0 : exp_db(m_act_b, 1'b0));
    chk({req, " mute_a"}, int'(mute_a), int'(m_mute_a));
    chk({req, " mute_b"}, int'(mute_b), int'(m_mute_b | m_diff));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [8:0] d;
    logic [1:0] a;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gain_a", int'(gain_a), 6);
    chk("R1 db_a", int'(db_a), 0);
    chk("R1 mute_a", int'(mute_a), 1);
    chk("R1 mute_b", int'(mute_b), 1);
    chk("R9 gain_b diff", int'(gain_b), 0);

    // random phase, zero-cross off: R2 R3 R8 R9 R10 R11
    for (int i = 0; i < 300; i++) begin
      a = 2'($urandom_range(0, 3));
      d = 9'($urandom);
      if (a == 0) d[1] = 1'b0;
      else d[7] = 1'b0;
      wr(a, d);
      case (a)
        2'd0: m_diff = d[0];
        2'd1: begin m_sh_a = d[5:0]; m_mute_a = d[6]; end
        2'd2: begin m_sh_b = d[5:0]; m_mute_b = d[6]; end
        default: ;
      endcase
      if ((a == 1 || a == 2) && d[8]) begin m_act_a = m_sh_a; m_act_b = m_sh_b; end
      chk_model("R2/R3/R8/R10/R11 random");
    end

    // directed: single-ended, codes with saturation R10
    wr(2'd0, 9'h000); m_diff = 0;
    wr(2'd1, {1'b1, 1'b0, 1'b0, 6'd40}); m_sh_a = 40; m_act_a = 40; m_act_b = m_sh_b; m_mute_a = 0;
    chk("R10 sat db_a se", int'(db_a), 24);
    wr(2'd0, 9'h001); m_diff = 1;
    chk("R10 sat db_a diff", int'(db_a), 18);
    chk("R9 mute_b diff", int'(mute_b), 1);
    wr(2'd0, 9'h000); m_diff = 0;
    wr(2'd3, 9'h1ff);
    chk_model("R11 addr3");

    // R4: A zc on, B zc off, same update write
    smp_a = 16'd5; smp_b = 16'd7;
    wr(2'd1, {1'b0, 1'b1, 1'b0, 6'd10});
    wr(2'd2, {1'b1, 1'b0, 1'b0, 6'd20});
    chk("R4 A waits", int'(gain_a), 40);
    chk("R4 B immediate", int'(gain_b), 20);
    repeat (5) @(negedge clk);
    chk("R4 A still waits", int'(gain_a), 40);
    smp_a = 16'hfffd;
    @(negedge clk);
    chk("R5 sign change commits A", int'(gain_a), 10);

    // R5 zero sample, R7 replacement
    wr(2'd1, {1'b1, 1'b1, 1'b0, 6'd12});
    chk("R4 A waits again", int'(gain_a), 10);
    wr(2'd1, {1'b1, 1'b1, 1'b0, 6'd14});
    wr(2'd1, {1'b0, 1'b1, 1'b0, 6'd30});
    repeat (3) @(negedge clk);
    chk("R7 still pending", int'(gain_a), 10);
    smp_a = 16'd0;
    @(negedge clk);
    chk("R7 newest request applied", int'(gain_a), 14);
    chk("R5 zero sample commits", int'(gain_a), 14);
    smp_a = 16'd9;
    @(negedge clk);
    chk("R2 later write not applied", int'(gain_a), 14);

    // R6: timeout disabled then enabled
    smp_a = 16'd9;
    tick = 1;
    wr(2'd1, {1'b1, 1'b1, 1'b0, 6'd3});
    repeat (400) @(negedge clk);
    chk("R6 no fire without enable", int'(gain_a), 14);
    wr(2'd0, 9'h002); // enable, rate 0
    wr(2'd1, {1'b1, 1'b1, 1'b0, 6'd4});
    repeat (255) @(negedge clk);
    chk("R6 rate0 before", int'(gain_a), 14);
    @(negedge clk);
    chk("R6 rate0 at 256", int'(gain_a), 4);
    wr(2'd0, 9'h006); // enable, rate 1
    wr(2'd1, {1'b1, 1'b1, 1'b0, 6'd8});
    repeat (1023) @(negedge clk);
    chk("R6 rate1 before", int'(gain_a), 4);
    @(negedge clk);
    chk("R6 rate1 at 1024", int'(gain_a), 8);
    tick = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule